// File: doc/BRIEF.md
# Extended IO Interrupt Aggregation Controller

This block collects a wide vector of level-sensitive interrupt sources and delivers them to a small set of cores. Each core has several interrupt pins. Every source has a raw pending bit, which follows the input on each clock, and an enable bit. A source whose enable bit is set and whose input is high is called active. When a source becomes active, the block latches it into a status word that belongs to the core the source is routed to. Each core/pin output is the OR of that core's latched status bits whose source group is routed to that pin.

Software reaches the block through a 32-bit register window. The window holds the enable words, the per-core status words, free storage words for bounce and node-type settings, a pin-routing byte for each group of 32 sources, and a core-routing byte for each source. Software acknowledges an interrupt by writing ones to the status word. The status words are selected by the requester ID that comes with the access, not by the address, so every core sees only its own status at the same offset. Writes to the enable words replay the currently pending sources: unmasking a pending source raises it and masking it lowers it.

Top module: `extio_ctrl`

## Requirements
- R1: After reset, every enable, status, bounce, node-type and routing word reads zero and every core/pin output is low.
- R2: Source n maps to word n/32, bit n mod 32 of the enable words at byte offset 0x000 and of the status words at byte offset 0x020 (default parameters, 4-byte words).
- R3: A source that rises while its enable bit is clear sets no status bit and changes no output.
- R4: When a source becomes active, the status bit is set for the core named by the source's core-routing byte. The byte for source n is byte n mod 4 (little-endian) of the word at 0x100 + 4*(n/4). The lowest set bit of the byte gives the core index. A zero byte, or an index of the core count or more, selects core 0.
- R5: The pin-routing byte for source group g (sources 32g..32g+31) is byte g mod 4 of the word at 0x080 + 4*(g/4). Its lowest set bit gives the pin, and a zero byte or an index of the pin count or more selects pin 0.
- R6: Output bit c*4+p is high exactly when core c holds at least one status bit whose group routes to pin p. It follows the status one clock after the causing input edge or write. It stays high while any such bit remains set.
- R7: When a source stops being active, its status bit is cleared in every core.
- R8: The raw pending bit is recorded even while the source is disabled. A write that changes an enable bit from 0 to 1 with the source high sets the status bit, and a change from 1 to 0 with the source high clears it.
- R9: Writing a status word clears exactly the bits written as one. A bit cleared this way stays clear while its source stays high, until the source becomes active again.
- R10: Reads and write-one-to-clear writes of the status words act on the core given by the requester ID input.
- R11: Bounce words at 0x040 and node-type words at 0x060 read back what was written and have no effect on status or outputs.
- R12: Reads of offsets outside the mapped words return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Level interrupt sources |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_core | input | CW | Requester ID: the core making the access |
| bus_rdata | output | 32 | Read data for bus_addr and bus_core, combinational |
| core_pin | output | NUM_CORE*NUM_PIN | Level outputs, bit c*NUM_PIN+p for core c, pin p |

## Verification
The hardest situation to reach is a source that is held high while its status is changed only by register traffic. In this situation the source is masked and unmasked, acknowledged from the owning core and from a foreign core, and other sources share the same pin. The stimulus holds a source high across these writes and keeps a second source on the same core and pin, so that clearing one bit must not drop the pin. A long random phase then mixes source toggles with enable, acknowledge and routing writes. A behavioural model in the bench checks the outputs on every clock.

// File: rtl/extio_pkg.sv
package extio_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Index of the lowest set bit of a routing byte; zero byte or an index
  // past the limit falls back to 0.
  function automatic int unsigned first_one_sel(input logic [7:0] b, input int unsigned lim);
    int unsigned sel;
    logic        seen;
    sel  = 0;
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!seen && b[i]) begin
        sel  = i;
        seen = 1'b1;
      end
    end
    if (sel >= lim) sel = 0;
    return sel;
  endfunction
endpackage

// File: rtl/extio_store.sv
module extio_store #(
  parameter int N_WORDS = 8,
  parameter int BASE    = 0,
  parameter int AW      = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [31:0]              wdata,
  output logic [N_WORDS-1:0][31:0] q,
  output logic [N_WORDS-1:0][31:0] q_next,
  output logic                     hit,
  output logic [31:0]              rd_word
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [AW-1:0] off;
  logic [IW-1:0] idx;

  assign off     = addr - AW'(BASE);
  assign hit     = (int'(addr) >= BASE) && (int'(addr) < BASE + 4 * N_WORDS);
  assign idx     = off[IW+1:2];
  assign rd_word = hit ? q[idx] : '0;

  always_comb begin
    q_next = q;
    if (wr_en && hit) q_next[idx] = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/extio_status.sv
module extio_status #(
  parameter int NUM_SRC = 256,
  parameter int CW      = 2,
  parameter int CORE_ID = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          act_rise,
  input  logic [NUM_SRC-1:0]          act_fall,
  input  logic [NUM_SRC-1:0][CW-1:0]  dest,
  input  logic [NUM_SRC-1:0]          w1c_mask,
  output logic [NUM_SRC-1:0]          status
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [NUM_SRC-1:0] mine;
  logic [NUM_SRC-1:0] set_now;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) mine[s] = (dest[s] == CW'(CORE_ID));
  end

  assign set_now = act_rise & mine;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status | set_now) & ~act_fall & ~w1c_mask;
  end

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_mask != '0) |=> ((status & $past(w1c_mask)) == '0));
endmodule

// File: rtl/extio_pin_merge.sv
module extio_pin_merge #(
  parameter int NUM_SRC = 256,
  parameter int NUM_PIN = 4,
  parameter int PW      = 2
) (
  input  logic [NUM_SRC-1:0]             status,
  input  logic [NUM_SRC/32-1:0][PW-1:0]  grp_pin,
  output logic [NUM_PIN-1:0]             pins
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    pins = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (status[s]) pins[grp_pin[s/32]] = 1'b1;
    end
  end
endmodule

// File: rtl/extio_ctrl.sv
module extio_ctrl #(
  parameter int NUM_SRC  = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_PIN  = 4,
  parameter int AW       = 10,
  localparam int CW      = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           irq_src,
  input  logic                         bus_wr,
  input  logic [AW-1:0]                bus_addr,
  input  logic [31:0]                  bus_wdata,
  input  logic [CW-1:0]                bus_core,
  output logic [31:0]                  bus_rdata,
  output logic [NUM_CORE*NUM_PIN-1:0]  core_pin
);
  timeunit 1ns;
  timeprecision 1ps;
  import extio_pkg::*;

  localparam int NW        = NUM_SRC / 32;
  localparam int PW        = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
  localparam int PRW       = (NW + 3) / 4;
  localparam int CRW       = NUM_SRC / 4;
  localparam int EN_BASE   = 0;
  localparam int ST_BASE   = 4 * NW;
  localparam int BNC_BASE  = 8 * NW;
  localparam int NODE_BASE = 12 * NW;
  localparam int PIN_BASE  = 16 * NW;
  localparam int CORE_BASE = 32 * NW;
  localparam int SIW       = (NW > 1) ? $clog2(NW) : 1;

  logic [NW-1:0][31:0]  en_w, en_wn, bnc_w, bnc_wn, node_w, node_wn;
  logic [PRW-1:0][31:0] pin_w, pin_wn;
  logic [CRW-1:0][31:0] core_w, core_wn;
  logic                 en_hit, bnc_hit, node_hit, pin_hit, core_hit;
  logic [31:0]          en_rd, bnc_rd, node_rd, pin_rd, core_rd;

  extio_store #(.N_WORDS(NW), .BASE(EN_BASE), .AW(AW)) u_en (
    .clk, .rst_n, .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .q(en_w), .q_next(en_wn), .hit(en_hit), .rd_word(en_rd));
  extio_store #(.N_WORDS(NW), .BASE(BNC_BASE), .AW(AW)) u_bnc (
    .clk, .rst_n, .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .q(bnc_w), .q_next(bnc_wn), .hit(bnc_hit), .rd_word(bnc_rd));
  extio_store #(.N_WORDS(NW), .BASE(NODE_BASE), .AW(AW)) u_node (
    .clk, .rst_n, .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .q(node_w), .q_next(node_wn), .hit(node_hit), .rd_word(node_rd));
  extio_store #(.N_WORDS(PRW), .BASE(PIN_BASE), .AW(AW)) u_pin (
    .clk, .rst_n, .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .q(pin_w), .q_next(pin_wn), .hit(pin_hit), .rd_word(pin_rd));
  extio_store #(.N_WORDS(CRW), .BASE(CORE_BASE), .AW(AW)) u_core (
    .clk, .rst_n, .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .q(core_w), .q_next(core_wn), .hit(core_hit), .rd_word(core_rd));

  // Raw pending follows the inputs regardless of enable.
  logic [NUM_SRC-1:0] pend_q, en_q, en_n, act_q, act_n, act_rise, act_fall;
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_src;
  end

  assign en_q     = en_w;
  assign en_n     = en_wn;
  assign act_q    = en_q & pend_q;
  assign act_n    = en_n & irq_src;
  assign act_rise = act_n & ~act_q;
  assign act_fall = act_q & ~act_n;

  // Routing decode.
  logic [NUM_SRC*8-1:0]         core_flat;
  logic [PRW*32-1:0]            pin_flat;
  logic [NUM_SRC-1:0][CW-1:0]   dest;
  logic [NW-1:0][PW-1:0]        grp_pin;
  assign core_flat = core_w;
  assign pin_flat  = pin_w;
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) dest[s] = CW'(first_one_sel(core_flat[8*s +: 8], NUM_CORE));
    for (int g = 0; g < NW; g++) grp_pin[g] = PW'(first_one_sel(pin_flat[8*g +: 8], NUM_PIN));
  end

  // Status window, selected by requester ID.
  logic [AW-1:0]  st_off;
  logic [SIW-1:0] st_idx;
  logic           st_hit, core_ok;
  assign st_off  = bus_addr - AW'(ST_BASE);
  assign st_idx  = st_off[SIW+1:2];
  assign st_hit  = (int'(bus_addr) >= ST_BASE) && (int'(bus_addr) < ST_BASE + 4 * NW);
  assign core_ok = int'(bus_core) < NUM_CORE;

  logic [NUM_CORE-1:0][NW-1:0][31:0] stat_w;
  logic [NUM_SRC-1:0]                stat_or;
  logic [31:0]                       st_rd;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    logic [NW-1:0][31:0] clr_w;
    always_comb begin
      clr_w = '0;
      if (bus_wr && st_hit && bus_core == CW'(c)) clr_w[st_idx] = bus_wdata;
    end
    extio_status #(.NUM_SRC(NUM_SRC), .CW(CW), .CORE_ID(c)) u_st (
      .clk, .rst_n, .act_rise, .act_fall, .dest, .w1c_mask(clr_w), .status(stat_w[c]));
    extio_pin_merge #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN), .PW(PW)) u_merge (
      .status(stat_w[c]), .grp_pin, .pins(core_pin[c*NUM_PIN +: NUM_PIN]));

    // R6
    pin_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_pin[c*NUM_PIN +: NUM_PIN]) == (|stat_w[c]));
  end

  always_comb begin
    stat_or = '0;
    for (int c = 0; c < NUM_CORE; c++) stat_or = stat_or | stat_w[c];
  end

  assign st_rd     = (st_hit && core_ok) ? stat_w[bus_core][st_idx] : '0;
  assign bus_rdata = en_rd | st_rd | bnc_rd | node_rd | pin_rd | core_rd;

  // R3
  set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_or & ~$past(stat_or) & ~en_q) == '0));
  // R7
  fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_or & $past(pend_q & ~irq_src)) == '0));
endmodule

// File: tb/extio_ctrl_test.sv
module extio_ctrl_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 256, NC = 4, NP = 4, NW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [NS-1:0]   src;
  logic            wr;
  logic [9:0]      addr;
  logic [31:0]     wdata;
  logic [1:0]      rcore;
  logic [31:0]     rdata;
  logic [NC*NP-1:0] pins;

  extio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_core(rcore), .bus_rdata(rdata), .core_pin(pins));

  bit        m_en[NS];
  bit        m_pend[NS];
  bit        m_st[NC][NS];
  bit [31:0] m_bnc[NW], m_node[NW], m_pin[2], m_core[64];
  int        total = 0, bad = 0;
  bit        done = 0;

  function automatic int pick(bit [7:0] b, int lim);
    int r = 0;
    for (int i = 7; i >= 0; i--) if (b[i]) r = i;
    return (r >= lim) ? 0 : r;
  endfunction

  function automatic bit [7:0] core_byte(int s);
    return m_core[s/4][8*(s%4) +: 8];
  endfunction

  function automatic bit [7:0] pin_byte(int g);
    return m_pin[g/4][8*(g%4) +: 8];
  endfunction

  function automatic bit [31:0] mread(int a, int rc);
    bit [31:0] v = 0;
    if (a < 32)       for (int b = 0; b < 32; b++) v[b] = m_en[(a/4)*32 + b];
    else if (a < 64)  for (int b = 0; b < 32; b++) v[b] = m_st[rc][((a-32)/4)*32 + b];
    else if (a < 96)  v = m_bnc[(a-64)/4];
    else if (a < 128) v = m_node[(a-96)/4];
    else if (a < 136) v = m_pin[(a-128)/4];
    else if (a >= 256 && a < 512) v = m_core[(a-256)/4];
    return v;
  endfunction

  function automatic bit [NC*NP-1:0] mpins();
    bit [NC*NP-1:0] v = 0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (m_st[c][s]) v[c*NP + pick(pin_byte(s/32), NP)] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, bit [31:0] got, bit [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model_update();
    int a = int'(addr);
    bit en_new[NS];
    for (int s = 0; s < NS; s++) begin
      bit oa, na;
      en_new[s] = m_en[s];
      if (wr && a < 32 && a/4 == s/32) en_new[s] = wdata[s%32];
      oa = m_en[s] & m_pend[s];
      na = en_new[s] & src[s];
      if (na && !oa) m_st[pick(core_byte(s), NC)][s] = 1;
      if (oa && !na) for (int c = 0; c < NC; c++) m_st[c][s] = 0;
    end
    if (wr && a >= 32 && a < 64)
      for (int b = 0; b < 32; b++) if (wdata[b]) m_st[rcore][((a-32)/4)*32 + b] = 0;
    if (wr) begin
      if (a >= 64 && a < 96)        m_bnc[(a-64)/4] = wdata;
      else if (a >= 96 && a < 128)  m_node[(a-96)/4] = wdata;
      else if (a >= 128 && a < 136) m_pin[(a-128)/4] = wdata;
      else if (a >= 256 && a < 512) m_core[(a-256)/4] = wdata;
    end
    for (int s = 0; s < NS; s++) begin
      m_en[s]   = en_new[s];
      m_pend[s] = src[s];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check("R6 pins", 32'(pins), 32'(mpins()));
    wr = 1'b0;
  endtask

  task automatic bus_write(int a, bit [31:0] d, int rc);
    addr = 10'(a); wdata = d; rcore = 2'(rc); wr = 1'b1;
    tick();
  endtask

  task automatic set_src(int n, bit v);
    src[n] = v;
    tick();
  endtask

  task automatic rd_check(string tag, int a, int rc);
    addr = 10'(a); rcore = 2'(rc); wr = 1'b0;
    #1;
    check(tag, rdata, mread(a, rc));
  endtask

  task automatic rd_expect(string tag, int a, int rc, bit [31:0] exp);
    addr = 10'(a); rcore = 2'(rc); wr = 1'b0;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; wr = 1'b0; addr = '0; wdata = '0; rcore = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd_expect("R1 enable", 10'h000, 0, 0);
    rd_expect("R1 status", 10'h03C, 3, 0);
    rd_expect("R1 bounce", 10'h040, 0, 0);
    rd_expect("R1 node", 10'h07C, 0, 0);
    rd_expect("R1 pinroute", 10'h080, 0, 0);
    rd_expect("R1 coreroute", 10'h1FC, 0, 0);
    check("R1 pins", 32'(pins), 0);

    // Routing: src5,6 -> core2; src40 -> core1; src70 -> core3; src100 byte 0x30 -> core0
    bus_write(10'h104, 32'h0004_0400, 0);
    bus_write(10'h128, 32'h0000_0002, 0);
    bus_write(10'h144, 32'h0008_0000, 0);
    bus_write(10'h164, 32'h0000_0030, 0);
    // R5: groups 0->pin3, 1->pin1, 2->pin0 (zero), 3 -> bit6 out of range -> pin0
    bus_write(10'h080, 32'h4000_0208, 0);
    rd_expect("R5 pinroute readback", 10'h080, 0, 32'h4000_0208);

    // R3: disabled source
    set_src(5, 1);
    rd_expect("R3 no status", 10'h020, 2, 0);
    check("R3 pins low", 32'(pins), 0);

    // R8: unmask pending source
    bus_write(10'h000, 32'h0000_0020, 0);
    rd_expect("R8 unmask sets", 10'h020, 2, 32'h0000_0020);
    check("R6 core2 pin3", 32'(pins[2*NP+3]), 1);
    rd_expect("R2 enable word0", 10'h000, 0, 32'h0000_0020);

    // Enable everything
    for (int w = 0; w < NW; w++) bus_write(4*w, 32'hFFFF_FFFF, 0);
    set_src(40, 1);
    rd_expect("R4 core1 status word1", 10'h024, 1, 32'h0000_0100);
    rd_expect("R2 other core clear", 10'h024, 0, 0);
    check("R5 core1 pin1", 32'(pins[1*NP+1]), 1);
    set_src(70, 1);
    rd_expect("R4 core3 status word2", 10'h028, 3, 32'h0000_0040);
    check("R5 core3 pin0", 32'(pins[3*NP+0]), 1);
    set_src(100, 1);
    rd_expect("R4 out of range to core0", 10'h02C, 0, 32'h0000_0010);
    check("R5 core0 pin0", 32'(pins[0*NP+0]), 1);

    // R6/R7: shared pin
    set_src(6, 1);
    set_src(5, 0);
    rd_expect("R7 fall clears", 10'h020, 2, 32'h0000_0040);
    check("R6 shared pin held", 32'(pins[2*NP+3]), 1);
    set_src(6, 0);
    check("R6 pin drops", 32'(pins[2*NP+3]), 0);

    // R10: W1C from wrong core has no effect
    bus_write(10'h024, 32'h0000_0100, 0);
    rd_expect("R10 foreign clear ignored", 10'h024, 1, 32'h0000_0100);
    // R9: W1C from owner
    bus_write(10'h024, 32'h0000_0300, 1);
    rd_expect("R9 w1c clears", 10'h024, 1, 0);
    check("R9 pin low", 32'(pins[1*NP+1]), 0);
    tick();
    rd_expect("R9 stays clear", 10'h024, 1, 0);
    set_src(40, 0);
    set_src(40, 1);
    rd_expect("R9 reassert", 10'h024, 1, 32'h0000_0100);

    // R8: mask / unmask with source held
    bus_write(10'h008, 32'h0000_0000, 0);
    rd_expect("R8 mask lowers", 10'h028, 3, 0);
    check("R8 pin low", 32'(pins[3*NP+0]), 0);
    bus_write(10'h008, 32'hFFFF_FFFF, 0);
    rd_expect("R8 remask raise", 10'h028, 3, 32'h0000_0040);

    // R11: storage only
    bus_write(10'h044, 32'hA5A5_0F0F, 0);
    bus_write(10'h06C, 32'h1234_5678, 0);
    rd_expect("R11 bounce", 10'h044, 0, 32'hA5A5_0F0F);
    rd_expect("R11 node", 10'h06C, 0, 32'h1234_5678);
    rd_check("R11 status untouched", 10'h028, 3);

    // R12: unmapped
    bus_write(10'h088, 32'hFFFF_FFFF, 0);
    bus_write(10'h300, 32'hFFFF_FFFF, 0);
    rd_expect("R12 read 0x088", 10'h088, 0, 0);
    rd_expect("R12 read 0x300", 10'h300, 0, 0);
    rd_check("R12 pinroute intact", 10'h080, 0);

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 60) begin
        int n = $urandom_range(0, NS-1);
        set_src(n, ~src[n]);
      end else if (r < 72) bus_write(4 * $urandom_range(0, NW-1), $urandom(), 0);
      else if (r < 86) bus_write(32 + 4 * $urandom_range(0, NW-1), $urandom(), $urandom_range(0, NC-1));
      else if (r < 93) bus_write(256 + 4 * $urandom_range(0, 63), $urandom(), 0);
      else if (r < 96) bus_write(128 + 4 * $urandom_range(0, 1), $urandom(), 0);
      else rd_check("R10 random status read", 32 + 4 * $urandom_range(0, NW-1), $urandom_range(0, NC-1));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule